// File: doc/BRIEF.md
# I2C Bus Timeout Timer

This block watches an I2C master for a stalled bus. It counts whole SCL bit periods, using a one-cycle strobe that the clock generator issues once per bit period. If a programmed number of bit periods passes without any bus activity that restarts the count, it raises a sticky timeout flag. Three events restart the count: a START request, a STOP request and a falling edge on SCL. Software may also clear the flag, which restarts the count as well.

An 8-bit interval register sets the length of the wait. A value of N other than zero gives a timeout of N+1 bit periods. A value of zero turns the timer off. The register value is copied into the timer only when the count restarts, so a write takes effect at the next restart. The SCL input passes through a synchronizer, and only a high-to-low transition of the synchronized level counts as activity. The flag stays set until a clear pulse arrives, and the count is frozen while the flag is set.

Top module: `i2c_timeout_timer`

## Requirements
- R1: After reset the flag is 0 and the copied interval is 0, so the timer stays off until the first restart event, whatever the register holds.
- R2: After a restart that copies a register value N not equal to 0, the flag rises at the clock edge that samples the (N+1)-th bit strobe after the restart. It is still 0 after N strobes.
- R3: While the copied interval is 0, the flag never rises, however many bit strobes arrive.
- R4: A pulse on `startReq` sets the count to zero and copies the register.
- R5: A pulse on `stopReq` sets the count to zero and copies the register.
- R6: A high-to-low transition of synchronized SCL sets the count to zero and copies the register. SCL held low does not keep restarting the count, and a rising SCL does not restart it.
- R7: Once set, the flag stays 1 until a clear pulse, and bit strobes do not advance the count while the flag is set.
- R8: A pulse on `flagClr` drives the flag to 0 at the next edge, sets the count to zero and copies the register.
- R9: A register write takes effect only at the next restart event. Until then the previously copied interval governs the timeout.
- R10: When a restart event and a bit strobe arrive in the same cycle, the restart wins and that strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| toReg | input | 8 | Timeout interval register (0 = off) |
| bitTick | input | 1 | One-cycle strobe, once per SCL bit period |
| startReq | input | 1 | Pulse when a START request is issued |
| stopReq | input | 1 | Pulse when a STOP request is issued |
| sclIn | input | 1 | SCL line level, asynchronous |
| flagClr | input | 1 | Write-one-to-clear pulse for the flag |
| toFlag | output | 1 | Sticky timeout flag |

## Verification
The assertions check several rules on every cycle:
- the flag holds until a clear pulse and falls right after one;
- the count never advances while the flag is set;
- START and STOP zero the count;
- the flag rises only on a bit strobe that comes with no request or clear in the same cycle;
- the flag never rises when the copied interval is zero.

Only the bench scenarios can show the exact interval length and the one-period boundary. The same applies to delayed register adoption, SCL edge versus level behaviour, and priority of a restart over a coincident strobe. These need a known history of strobes and events.

// File: rtl/i2c_to_pkg.sv
package i2c_to_pkg;
  typedef struct packed {
    logic restart;
    logic advance;
    logic expire;
  } toStrobes_t;
endpackage

// File: rtl/i2c_to_ctrl.sv
module i2c_to_ctrl
  import i2c_to_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       sclIn,
  input  logic       flagClr,
  input  logic       enabled,
  input  logic       atLimit,
  output toStrobes_t strobes,
  output logic       toFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic sclPrev;
  logic sclFall;
  logic counting;

  // SCL synchronizer; idle bus level is high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= sclIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sclIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclPrev <= 1'b1;
    else       sclPrev <= syncQ[LAST];
  end

  assign sclFall = sclPrev & ~syncQ[LAST];

  always_comb begin
    strobes.restart = startReq | stopReq | sclFall | flagClr;
    counting        = bitTick & enabled & ~toFlag & ~strobes.restart;
    strobes.advance = counting & ~atLimit;
    strobes.expire  = counting & atLimit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               toFlag <= 1'b0;
    else if (flagClr)        toFlag <= 1'b0;
    else if (strobes.expire) toFlag <= 1'b1;
  end
endmodule

// File: rtl/i2c_to_dp.sv
module i2c_to_dp
  import i2c_to_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] toReg,
  input  toStrobes_t       strobes,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] activeLim,
  output logic             enabled,
  output logic             atLimit
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      activeLim <= '0;
    end else if (strobes.restart) begin
      count     <= '0;
      activeLim <= toReg;
    end else if (strobes.advance) begin
      count     <= count + CNT_W'(1);
    end
  end

  assign enabled = (activeLim != '0);
  assign atLimit = (count == activeLim);
endmodule

// File: rtl/i2c_timeout_timer.sv
module i2c_timeout_timer
  import i2c_to_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] toReg,
  input  logic             bitTick,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic             sclIn,
  input  logic             flagClr,
  output logic             toFlag
);
  toStrobes_t       strobes;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] activeLim;
  logic             enabled;
  logic             atLimit;

  i2c_to_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startReq(startReq),
    .stopReq(stopReq), .sclIn(sclIn), .flagClr(flagClr),
    .enabled(enabled), .atLimit(atLimit), .strobes(strobes), .toFlag(toFlag)
  );

  i2c_to_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .toReg(toReg), .strobes(strobes),
    .count(count), .activeLim(activeLim), .enabled(enabled), .atLimit(atLimit)
  );
endmodule

// File: rtl/i2c_timeout_timer_chk.sv
module i2c_timeout_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitTick,
  input logic             startReq,
  input logic             stopReq,
  input logic             flagClr,
  input logic             toFlag,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] activeLim
);
  assert_flag_needs_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> $past(bitTick && !startReq && !stopReq && !flagClr));

  assert_off_when_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> ($past(activeLim) != '0));

  assert_start_zeroes_R4: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (count == '0));

  assert_stop_zeroes_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (count == '0));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !flagClr) |=> toFlag);

  assert_frozen_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !flagClr) |=> (count != $past(count) + CNT_W'(1)));

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |=> (!toFlag && count == '0));
endmodule

bind i2c_timeout_timer i2c_timeout_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .startReq(startReq),
  .stopReq(stopReq), .flagClr(flagClr), .toFlag(toFlag),
  .count(count), .activeLim(activeLim)
);

// File: tb/sim_i2c_timeout_timer.sv
module sim_i2c_timeout_timer;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] toReg = '0;
  logic       bitTick = 1'b0;
  logic       startReq = 1'b0;
  logic       stopReq = 1'b0;
  logic       sclIn = 1'b1;
  logic       flagClr = 1'b0;
  logic       toFlag;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_timeout_timer u0 (
    .clk(clk), .rstN(rstN), .toReg(toReg), .bitTick(bitTick),
    .startReq(startReq), .stopReq(stopReq), .sclIn(sclIn),
    .flagClr(flagClr), .toFlag(toFlag)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: toFlag=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bitTick = 1'b1;
      @(negedge clk); bitTick = 1'b0;
    end
  endtask

  task automatic pulseClr();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
  endtask

  task automatic testReset();
    check(toFlag, 1'b0, "R1 reset state");
    toReg = 8'd3;
    ticks(10);
    check(toFlag, 1'b0, "R1 off until first restart");
  endtask

  task automatic testInterval();
    pulseStop();
    ticks(3);
    check(toFlag, 1'b0, "R2 not yet after N ticks");
    ticks(1);
    check(toFlag, 1'b1, "R2 expiry at N+1 ticks");
  endtask

  task automatic testSticky();
    ticks(5);
    check(toFlag, 1'b1, "R7 flag stays set");
    pulseClr();
    check(toFlag, 1'b0, "R8 clear drops flag");
    ticks(3);
    check(toFlag, 1'b0, "R8 count restarted by clear");
    ticks(1);
    check(toFlag, 1'b1, "R8 expiry after clear restart");
  endtask

  task automatic testStart();
    pulseClr();
    ticks(2);
    pulseStart();
    ticks(3);
    check(toFlag, 1'b0, "R4 start restarts count");
    ticks(1);
    check(toFlag, 1'b1, "R4 expiry after start");
  endtask

  task automatic testStop();
    pulseClr();
    ticks(2);
    pulseStop();
    ticks(3);
    check(toFlag, 1'b0, "R5 stop restarts count");
    ticks(1);
    check(toFlag, 1'b1, "R5 expiry after stop");
  endtask

  task automatic testScl();
    pulseClr();
    ticks(2);
    sclIn = 1'b0;
    idle(5);
    ticks(3);
    check(toFlag, 1'b0, "R6 SCL fall restarts count");
    ticks(1);
    check(toFlag, 1'b1, "R6 SCL low level does not restart");
    pulseClr();
    ticks(2);
    sclIn = 1'b1;
    idle(5);
    ticks(2);
    check(toFlag, 1'b1, "R6 SCL rise does not restart");
  endtask

  task automatic testDeferred();
    pulseClr();
    toReg = 8'd1;
    ticks(3);
    check(toFlag, 1'b0, "R9 old interval still active");
    ticks(1);
    check(toFlag, 1'b1, "R9 old interval expiry");
    pulseClr();
    ticks(1);
    check(toFlag, 1'b0, "R9 new interval not yet");
    ticks(1);
    check(toFlag, 1'b1, "R9 new interval after restart");
  endtask

  task automatic testZero();
    toReg = 8'd0;
    pulseClr();
    ticks(300);
    check(toFlag, 1'b0, "R3 zero interval never expires");
    toReg = 8'd2;
    ticks(5);
    check(toFlag, 1'b0, "R3 still off before restart");
    pulseStart();
    ticks(2);
    check(toFlag, 1'b0, "R3 re-enabled not yet");
    ticks(1);
    check(toFlag, 1'b1, "R3 re-enabled expiry");
  endtask

  task automatic testPriority();
    toReg = 8'd2;
    pulseClr();
    ticks(2);
    @(negedge clk); startReq = 1'b1; bitTick = 1'b1;
    @(negedge clk); startReq = 1'b0; bitTick = 1'b0;
    ticks(2);
    check(toFlag, 1'b0, "R10 coincident tick not counted");
    ticks(1);
    check(toFlag, 1'b1, "R10 expiry after restart");
  endtask

  task automatic testMax();
    toReg = 8'd255;
    pulseClr();
    ticks(255);
    check(toFlag, 1'b0, "R2 max interval not yet");
    ticks(1);
    check(toFlag, 1'b1, "R2 max interval expiry");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset();
    testInterval();
    testSticky();
    testStart();
    testStop();
    testScl();
    testDeferred();
    testZero();
    testPriority();
    testMax();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule